// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

This peripheral holds two independent up-counting channels behind a small 32-bit register bus. Each channel picks a tick source through a 4-bit select field. Only one code connects the crystal tick, and every other code leaves the channel with no clock. The chosen tick goes through an 8-bit prescaler that divides by the field value plus one. The prescaled step then advances a 32-bit counter toward that channel's compare-0 value. A match sets a sticky pending flag, and the channel's interrupt line is that flag gated by its enable bit. Software clears the flag by writing 1 to bit 0 of the channel's clear register.

A channel is stopped by selecting no clock. The count freezes in place, and software can still read it to work out the time left before the compare value. A shared register holds the per-channel enable bit and counter-clear bit. Holding the clear bit forces the counter and prescaler to zero, but only on ticks of a running source. Software therefore selects the crystal tick, sets the clear bit, polls the counter until it reads zero, and then releases the bit. A per-channel mode bit chooses between reload on match and free counting. In free counting the count wraps from all ones to zero.

All logic runs in one system clock domain, and the crystal tick arrives as a one-cycle enable. The asynchronous active-low reset is released through a synchronizer. Register writes take effect at the clock edge where the write strobe is high. Reads are combinational from the current address.

Top module: `dual_match_timer`

## Requirements
- R1: After reset every register reads 0, both counters read 0 and both interrupt lines are low.
- R2: The registers read back exactly their defined bits, and every other bit reads 0:
  - source select at 0x00: channel 0 in [3:0], channel 1 in [7:4];
  - compare at 0x10 (channel 0) and 0x1C (channel 1): all 32 bits;
  - interrupt enable at 0x44 (channel 0) and 0x48 (channel 1): bit 0;
  - enable/clear at 0x84: enable bits 1 and 2, clear bits 5 and 6 for channels 0 and 1;
  - mode at 0x88: bits 1 and 2;
  - prescaler at 0xBC: [15:8] for channel 0, [23:16] for channel 1.

  The counters read at 0x2C and 0x30, and the interrupt clear registers at 0x78 and 0x7C read as 0.
- R3: With source code 3 selected and its enable bit set, a channel's counter advances by one on every (prescaler+1)-th crystal tick, counted from the last clear.
- R4: With the enable bit at 0, crystal ticks do not change the counter.
- R5: A select code other than 3 (for example 5 or 7) freezes the counter. The frozen value reads back, and counting resumes from it when code 3 is selected again.
- R6: While the clear bit is held and code 3 is selected, each crystal tick forces the counter to 0, and the counter stays at 0. While no source is selected, the clear bit has no effect on the count.
- R7: With the mode bit at 0, a step taken while the counter equals the compare value returns it to 0. A step whose new count equals the compare value sets the pending flag.
- R8: With the mode bit at 1, the counter keeps incrementing past the compare value after a match.
- R9: The pending flag is sticky. The interrupt line is high exactly when the flag and bit 0 of the interrupt enable register are both 1.
- R10: Writing 1 to bit 0 of a channel's interrupt clear register clears its pending flag, and writing 0 there has no effect.
- R11: The two channels are independent. Configuring and running channel 1 leaves the count and interrupt of a frozen channel 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | Crystal tick enable, one cycle per tick |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 2 | Compare-0 interrupt per channel (bit n = channel n) |

## Verification
The bench feeds an exact number of crystal ticks, so prescaler phase errors show up as an off-by-one count. A divider that divides by the field value instead of value plus one, or that does not restart on clear, would read the wrong number. A design that honoured the clear bit without a running source would zero a frozen count, and one that let the clear bit go while ticking would drift away from zero. Reload and free-running channels are driven through a match and beyond it, which exposes a counter that reloads or fails to reload in the wrong mode. The bench also checks that the pending flag survives until 1 is written to the clear register, and that it appears on the interrupt line once its enable is raised. Channel 1 is run with a frozen channel 0 to catch swapped field positions or shared state between the channels.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int NCH    = 2;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_SRCSEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CMP0   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CMP1   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CNT0   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_CNT1   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_IE0    = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_IE1    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_ICLR0  = 8'h78;
  localparam logic [ADDR_W-1:0] OFS_ICLR1  = 8'h7C;
  localparam logic [ADDR_W-1:0] OFS_ENCLR  = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h88;
  localparam logic [ADDR_W-1:0] OFS_PRESC  = 8'hBC;

  // bit placement inside the shared registers
  localparam int EN_LSB    = 1;
  localparam int CLR_LSB   = 5;
  localparam int MODE_LSB  = 1;
  localparam int PRESC_LSB = 8;

  // source codes: only the crystal code drives a tick
  localparam int SRC_XTAL = 3;
  localparam int SRC_OFF  = 5;
endpackage

// File: rtl/dmt_rst_sync.sv
module dmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dmt_regs.sv
module dmt_regs
  import dmt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 8,
  parameter int SEL_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        we,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  input  logic [NCH-1:0][CNT_W-1:0]   cnt_i,
  output logic [NCH-1:0][SEL_W-1:0]   sel_o,
  output logic [NCH-1:0]              en_o,
  output logic [NCH-1:0]              clr_o,
  output logic [NCH-1:0]              mode_o,
  output logic [NCH-1:0][DIV_W-1:0]   div_o,
  output logic [NCH-1:0][CNT_W-1:0]   cmp_o,
  output logic [NCH-1:0]              ie_o,
  output logic [NCH-1:0]              iclr_o
);
  logic [NCH-1:0][SEL_W-1:0] sel_q,  sel_d;
  logic [NCH-1:0]            en_q,   en_d;
  logic [NCH-1:0]            clr_q,  clr_d;
  logic [NCH-1:0]            mode_q, mode_d;
  logic [NCH-1:0][DIV_W-1:0] div_q,  div_d;
  logic [NCH-1:0][CNT_W-1:0] cmp_q,  cmp_d;
  logic [NCH-1:0]            ie_q,   ie_d;

  // write decode / next state
  always_comb begin
    sel_d  = sel_q;
    en_d   = en_q;
    clr_d  = clr_q;
    mode_d = mode_q;
    div_d  = div_q;
    cmp_d  = cmp_q;
    ie_d   = ie_q;
    iclr_o = '0;
    if (we) begin
      case (addr)
        OFS_SRCSEL: for (int c = 0; c < NCH; c++) sel_d[c] = wdata[c*SEL_W +: SEL_W];
        OFS_CMP0:   cmp_d[0] = wdata[CNT_W-1:0];
        OFS_CMP1:   cmp_d[1] = wdata[CNT_W-1:0];
        OFS_IE0:    ie_d[0]  = wdata[0];
        OFS_IE1:    ie_d[1]  = wdata[0];
        OFS_ICLR0:  iclr_o[0] = wdata[0];
        OFS_ICLR1:  iclr_o[1] = wdata[0];
        OFS_ENCLR: begin
          for (int c = 0; c < NCH; c++) begin
            en_d[c]  = wdata[EN_LSB + c];
            clr_d[c] = wdata[CLR_LSB + c];
          end
        end
        OFS_MODE:   for (int c = 0; c < NCH; c++) mode_d[c] = wdata[MODE_LSB + c];
        OFS_PRESC:  for (int c = 0; c < NCH; c++) div_d[c] = wdata[PRESC_LSB + c*DIV_W +: DIV_W];
        default: ;
      endcase
    end
  end

  // register process, clock enable = write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      en_q   <= '0;
      clr_q  <= '0;
      mode_q <= '0;
      div_q  <= '0;
      cmp_q  <= '0;
      ie_q   <= '0;
    end else if (we) begin
      sel_q  <= sel_d;
      en_q   <= en_d;
      clr_q  <= clr_d;
      mode_q <= mode_d;
      div_q  <= div_d;
      cmp_q  <= cmp_d;
      ie_q   <= ie_d;
    end
  end

  // readback mux
  always_comb begin
    rdata = '0;
    case (addr)
      OFS_SRCSEL: for (int c = 0; c < NCH; c++) rdata[c*SEL_W +: SEL_W] = sel_q[c];
      OFS_CMP0:   rdata[CNT_W-1:0] = cmp_q[0];
      OFS_CMP1:   rdata[CNT_W-1:0] = cmp_q[1];
      OFS_CNT0:   rdata[CNT_W-1:0] = cnt_i[0];
      OFS_CNT1:   rdata[CNT_W-1:0] = cnt_i[1];
      OFS_IE0:    rdata[0] = ie_q[0];
      OFS_IE1:    rdata[0] = ie_q[1];
      OFS_ENCLR: begin
        for (int c = 0; c < NCH; c++) begin
          rdata[EN_LSB + c]  = en_q[c];
          rdata[CLR_LSB + c] = clr_q[c];
        end
      end
      OFS_MODE:   for (int c = 0; c < NCH; c++) rdata[MODE_LSB + c] = mode_q[c];
      OFS_PRESC:  for (int c = 0; c < NCH; c++) rdata[PRESC_LSB + c*DIV_W +: DIV_W] = div_q[c];
      default: ;
    endcase
  end

  assign sel_o  = sel_q;
  assign en_o   = en_q;
  assign clr_o  = clr_q;
  assign mode_o = mode_q;
  assign div_o  = div_q;
  assign cmp_o  = cmp_q;
  assign ie_o   = ie_q;
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel #(
  parameter int CNT_W    = 32,
  parameter int DIV_W    = 8,
  parameter int SEL_W    = 4,
  parameter int SRC_CODE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  input  logic             clr,
  input  logic             free_run,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] cmp,
  input  logic             iclr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_o,
  output logic             match_o,
  output logic             pend_o
);
  localparam logic [SEL_W-1:0] SRC_SEL = SEL_W'(SRC_CODE);

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             run, pre_last, step, wrap_now, match, cnt_ce;
  logic [CNT_W-1:0] cnt_after;

  assign run       = tick && (sel == SRC_SEL);
  assign pre_last  = (pre_q >= div);
  assign step      = run && en && !clr && pre_last;
  assign wrap_now  = !free_run && (cnt_q == cmp);
  assign cnt_after = wrap_now ? '0 : cnt_q + 1'b1;
  assign match     = step && (cnt_after == cmp);
  assign cnt_ce    = run && (clr || en);

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (clr) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (pre_last) begin
      pre_d = '0;
      cnt_d = cnt_after;
    end else begin
      pre_d = pre_q + 1'b1;
    end
    pend_d = match || (pend_q && !iclr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (cnt_ce) begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign cnt_o   = cnt_q;
  assign step_o  = step;
  assign match_o = match;
  assign pend_o  = pend_q;
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int DIV_W       = 8,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq
);
  logic                      rst_core_n;
  logic [NCH-1:0][SEL_W-1:0] ch_sel;
  logic [NCH-1:0]            ch_en, ch_clr, ch_mode, ch_ie, ch_iclr;
  logic [NCH-1:0][DIV_W-1:0] ch_div;
  logic [NCH-1:0][CNT_W-1:0] ch_cmp, ch_cnt;
  logic [NCH-1:0]            ch_step, ch_match, ch_pend;

  dmt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  dmt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .addr   (bus_addr),
    .we     (bus_we),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .cnt_i  (ch_cnt),
    .sel_o  (ch_sel),
    .en_o   (ch_en),
    .clr_o  (ch_clr),
    .mode_o (ch_mode),
    .div_o  (ch_div),
    .cmp_o  (ch_cmp),
    .ie_o   (ch_ie),
    .iclr_o (ch_iclr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmt_channel #(
      .CNT_W(CNT_W), .DIV_W(DIV_W), .SEL_W(SEL_W), .SRC_CODE(SRC_XTAL)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .tick     (xtal_tick),
      .sel      (ch_sel[c]),
      .en       (ch_en[c]),
      .clr      (ch_clr[c]),
      .free_run (ch_mode[c]),
      .div      (ch_div[c]),
      .cmp      (ch_cmp[c]),
      .iclr     (ch_iclr[c]),
      .cnt_o    (ch_cnt[c]),
      .step_o   (ch_step[c]),
      .match_o  (ch_match[c]),
      .pend_o   (ch_pend[c])
    );
    assign irq[c] = ch_pend[c] & ch_ie[c];
  end
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
  import dmt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic [NCH-1:0][SEL_W-1:0] sel,
  input logic [NCH-1:0]            clr,
  input logic [NCH-1:0]            mode,
  input logic [NCH-1:0][CNT_W-1:0] cmp,
  input logic [NCH-1:0][CNT_W-1:0] cnt,
  input logic [NCH-1:0]            step,
  input logic [NCH-1:0]            match,
  input logic [NCH-1:0]            pend,
  input logic [NCH-1:0]            iclr
);
  localparam logic [SEL_W-1:0] XTAL = SEL_W'(SRC_XTAL);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt[c]) |-> $past(tick && (sel[c] == XTAL)));

    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[c] != XTAL) |=> $stable(cnt[c]));

    assert_clear_holds_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[c] && tick && (sel[c] == XTAL)) |=> (cnt[c] == '0));

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step[c] && !mode[c] && (cnt[c] == cmp[c])) |=> (cnt[c] == '0));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[c] && !iclr[c]) |=> pend[c]);

    assert_iclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (iclr[c] && !match[c]) |=> !pend[c]);
  end
endmodule

bind dual_match_timer dmt_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_dmt_checker (
  .clk   (clk),
  .rst_n (rst_core_n),
  .tick  (xtal_tick),
  .sel   (ch_sel),
  .clr   (ch_clr),
  .mode  (ch_mode),
  .cmp   (ch_cmp),
  .cnt   (ch_cnt),
  .step  (ch_step),
  .match (ch_match),
  .pend  (ch_pend),
  .iclr  (ch_iclr)
);

// File: tb/dual_match_timer_bench.sv
module dual_match_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal_tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] sh_sel = '0, sh_enclr = '0, sh_mode = '0, sh_div = '0;

  always #2 clk = ~clk;

  dual_match_timer u_dual_match_timer (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xtal_tick = 1'b1;
      @(negedge clk); xtal_tick = 1'b0;
    end
  endtask

  task automatic chk_cnt(input string req, input int ch, input logic [31:0] exp);
    logic [31:0] v;
    rd(ch == 0 ? 8'h2C : 8'h30, v);
    check(req, v, exp);
  endtask

  task automatic chk_irq(input string req, input logic [1:0] exp);
    @(negedge clk);
    #1 check(req, {30'd0, irq}, {30'd0, exp});
  endtask

  task automatic set_sel(input int ch, input logic [3:0] code);
    sh_sel[ch*4 +: 4] = code;
    wr(8'h00, sh_sel);
  endtask

  task automatic set_en(input int ch, input bit v);
    sh_enclr[1+ch] = v;
    wr(8'h84, sh_enclr);
  endtask

  task automatic set_clr(input int ch, input bit v);
    sh_enclr[5+ch] = v;
    wr(8'h84, sh_enclr);
  endtask

  task automatic set_mode(input int ch, input bit v);
    sh_mode[1+ch] = v;
    wr(8'h88, sh_mode);
  endtask

  task automatic set_div(input int ch, input logic [7:0] v);
    sh_div[8+ch*8 +: 8] = v;
    wr(8'hBC, sh_div);
  endtask

  task automatic do_clear(input int ch);
    set_sel(ch, 4'd3);
    set_clr(ch, 1'b1);
    pulse(1);
    set_clr(ch, 1'b0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    logic [7:0] offs [12] = '{8'h00, 8'h10, 8'h1C, 8'h2C, 8'h30, 8'h44,
                              8'h48, 8'h78, 8'h7C, 8'h84, 8'h88, 8'hBC};
    for (int i = 0; i < 12; i++) begin
      rd(offs[i], v);
      check("R1 reset register", v, 32'h0);
    end
    chk_irq("R1 reset irq", 2'b00);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 source select", v, 32'h0000_00FF);
    wr(8'h10, 32'hDEAD_BEEF); rd(8'h10, v); check("R2 compare ch0", v, 32'hDEAD_BEEF);
    wr(8'h1C, 32'h1234_5678); rd(8'h1C, v); check("R2 compare ch1", v, 32'h1234_5678);
    wr(8'hBC, 32'hFFFF_FFFF); rd(8'hBC, v); check("R2 prescaler", v, 32'h00FF_FF00);
    wr(8'h84, 32'hFFFF_FFFF); rd(8'h84, v); check("R2 enable/clear", v, 32'h0000_0066);
    wr(8'h88, 32'hFFFF_FFFF); rd(8'h88, v); check("R2 mode", v, 32'h0000_0006);
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, v); check("R2 irq enable ch0", v, 32'h1);
    rd(8'h78, v); check("R2 irq clear reads 0", v, 32'h0);
    wr(8'h84, 32'h0); wr(8'h00, 32'h0); wr(8'h88, 32'h0); wr(8'hBC, 32'h0);
    wr(8'h44, 32'h0); wr(8'h10, 32'h0); wr(8'h1C, 32'h0);
    wr(8'h78, 32'h1); wr(8'h7C, 32'h1);
  endtask

  task automatic t_count_div;
    set_mode(0, 1'b1);
    wr(8'h10, 32'd1000);
    set_div(0, 8'd0);
    do_clear(0);
    set_en(0, 1'b1);
    pulse(5);
    chk_cnt("R3 divide by 1", 0, 32'd5);
    set_div(0, 8'd3);
    do_clear(0);
    pulse(10);
    chk_cnt("R3 divide by 4, 10 ticks", 0, 32'd2);
    pulse(2);
    chk_cnt("R3 divide by 4, 12 ticks", 0, 32'd3);
  endtask

  task automatic t_enable;
    set_en(0, 1'b0);
    pulse(6);
    chk_cnt("R4 disabled holds", 0, 32'd3);
    set_en(0, 1'b1);
  endtask

  task automatic t_freeze;
    set_sel(0, 4'd5);
    pulse(8);
    chk_cnt("R5 code 5 freezes", 0, 32'd3);
    set_sel(0, 4'd7);
    pulse(8);
    chk_cnt("R5 code 7 freezes", 0, 32'd3);
    set_sel(0, 4'd3);
    pulse(4);
    chk_cnt("R5 resumes from frozen value", 0, 32'd4);
  endtask

  task automatic t_clear;
    set_sel(0, 4'd5);
    set_clr(0, 1'b1);
    pulse(3);
    chk_cnt("R6 clear ignored without source", 0, 32'd4);
    set_sel(0, 4'd3);
    pulse(1);
    chk_cnt("R6 clear with source", 0, 32'd0);
    pulse(5);
    chk_cnt("R6 held at zero", 0, 32'd0);
    set_clr(0, 1'b0);
    set_div(0, 8'd0);
    pulse(2);
    chk_cnt("R6 counts after release", 0, 32'd2);
  endtask

  task automatic t_reload;
    set_mode(0, 1'b0);
    do_clear(0);
    wr(8'h10, 32'd3);
    wr(8'h44, 32'h1);
    pulse(2);
    chk_irq("R7 no match before compare", 2'b00);
    pulse(1);
    chk_cnt("R7 reaches compare", 0, 32'd3);
    chk_irq("R7 match sets pending", 2'b01);
    pulse(1);
    chk_cnt("R7 reload to zero", 0, 32'd0);
    chk_irq("R9 pending sticky", 2'b01);
    wr(8'h78, 32'h0);
    chk_irq("R10 write 0 no effect", 2'b01);
    wr(8'h78, 32'h1);
    chk_irq("R10 write 1 clears", 2'b00);
    pulse(3);
    chk_irq("R7 second period match", 2'b01);
    wr(8'h78, 32'h1);
  endtask

  task automatic t_ie_gate;
    wr(8'h44, 32'h0);
    pulse(4);
    chk_cnt("R9 count at compare", 0, 32'd3);
    chk_irq("R9 enable off masks", 2'b00);
    wr(8'h44, 32'h1);
    chk_irq("R9 pending shows on enable", 2'b01);
    wr(8'h78, 32'h1);
  endtask

  task automatic t_freerun;
    set_mode(0, 1'b1);
    do_clear(0);
    wr(8'h10, 32'd2);
    pulse(2);
    chk_irq("R8 match in free mode", 2'b01);
    wr(8'h78, 32'h1);
    pulse(2);
    chk_cnt("R8 counts past compare", 0, 32'd4);
    chk_irq("R8 no repeat match", 2'b00);
  endtask

  task automatic t_chan1;
    set_sel(0, 4'd5);
    set_mode(1, 1'b0);
    set_div(1, 8'd1);
    wr(8'h1C, 32'd3);
    wr(8'h48, 32'h1);
    do_clear(1);
    set_en(1, 1'b1);
    pulse(6);
    chk_cnt("R11 ch1 divide by 2", 1, 32'd3);
    chk_irq("R11 only ch1 interrupt", 2'b10);
    chk_cnt("R11 ch0 untouched", 0, 32'd4);
    wr(8'h7C, 32'h1);
    chk_irq("R11 ch1 clear", 2'b00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    t_count_div();
    t_enable();
    t_freeze();
    t_clear();
    t_reload();
    t_ie_gate();
    t_freerun();
    t_chan1();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule